// File: doc/BRIEF.md
# Multicycle Unsigned Word Divider

This execution unit performs a processor's unsigned word divide. A 32-bit dividend is divided by a 16-bit divisor. The unit returns one 32-bit word that holds the 16-bit remainder in its upper half and the 16-bit quotient in its lower half. An operation starts with a one-cycle `start` pulse that carries the operands and the current condition flags. A one-cycle `done` pulse marks the result after a fixed 22-cycle latency.

Inside, the unit latches the operands on the accepting edge. It then runs a restoring shift-and-subtract loop that produces one quotient bit per cycle for 16 cycles, and pads the rest of the latency with idle cycles. The condition flags are derived from the divisor, not from the result. A separate `overflow_hint` output tells software that the result is not meaningful, either because of a zero divisor or because the quotient would not fit in 16 bits. The hint never changes the V flag.

Top module: `divu_unit`

## Requirements
- R1: When `overflow_hint` is 0 at `done`, `result[15:0]` equals dividend / divisor and `result[31:16]` equals dividend % divisor, both unsigned.
- R2: `done` is high for exactly one cycle. It rises after the 22nd rising edge that follows the edge on which `start` was accepted.
- R3: `busy` is 1 from the accepting edge until the edge that raises `done`. A `start` seen while `busy` is 1 is ignored and does not change the result of the running operation.
- R4: Flag bit 3 (N) of `flags_out` equals bit 15 of the accepted divisor.
- R5: Flag bit 2 (Z) of `flags_out` is 1 exactly when the accepted divisor is zero.
- R6: Flag bits 4 (H), 1 (V) and 0 (C) of `flags_out` equal the same bits of `flags_in` as sampled on the accepting edge.
- R7: `overflow_hint` is 1 exactly when the divisor is zero or dividend[31:16] >= divisor. The flag rules of R4 to R6 still apply in that case.
- R8: `result`, `flags_out` and `overflow_hint` change only on the edge that raises `done`, and hold their values until the next result.
- R9: After reset, `busy`, `done`, `result`, `flags_out` and `overflow_hint` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a divide; accepted only while not busy |
| dividend | input | 32 | Unsigned dividend, sampled on the accepting edge |
| divisor | input | 16 | Unsigned divisor, sampled on the accepting edge |
| flags_in | input | 5 | Current flags {H,N,Z,V,C}, sampled on the accepting edge |
| result | output | 32 | {remainder, quotient} |
| flags_out | output | 5 | Updated flags {H,N,Z,V,C} |
| overflow_hint | output | 1 | Result not meaningful (zero divisor or quotient overflow) |
| done | output | 1 | One-cycle result strobe |
| busy | output | 1 | Operation in progress |

## Verification
The bench targets the limit where the quotient fills all 16 bits and the remainder is divisor-1. A loop that ran one step too few or too many would return a halved or doubled quotient there. It also uses divisors with bit 15 set. An N flag taken from the quotient instead of the divisor would fail those cases, and so would a compare that was too narrow and dropped the carry bit. Zero-divisor and just-overflowing operands check that Z, N and the hint follow the divisor and that V stays as it came in. A design that let a mid-flight start reload the operands, or that put done one cycle early or late, would give the wrong result or the wrong strobe cycle in the injected-start and back-to-back scenarios.

// File: rtl/divu_pkg.sv
package divu_pkg;
   localparam int FLAG_W = 5;
   localparam int FLG_C  = 0;
   localparam int FLG_V  = 1;
   localparam int FLG_Z  = 2;
   localparam int FLG_N  = 3;
   localparam int FLG_H  = 4;
   typedef logic [FLAG_W-1:0] flags_t;
endpackage

// File: rtl/divu_ctrl.sv
module divu_ctrl #(
   parameter int LATENCY = 22,
   parameter int ITERS   = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic accept,
   output logic step,
   output logic finish,
   output logic busy,
   output logic done
);
   localparam int CW  = $clog2(LATENCY);
   localparam int PAD = LATENCY - 1 - ITERS;

   logic [CW-1:0] cnt_q;

   assign accept = start && !busy;
   assign finish = busy && (cnt_q == '0);
   assign step   = busy && (cnt_q > CW'(PAD));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         busy  <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= finish;
         if (accept) begin
            cnt_q <= CW'(LATENCY - 1);
            busy  <= 1'b1;
         end else if (busy) begin
            if (cnt_q == '0) busy <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
         end
      end
   end
endmodule

// File: rtl/divu_core.sv
module divu_core #(
   parameter int DIV_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               step,
   input  logic [2*DIV_W-1:0] dividend,
   input  logic [DIV_W-1:0]   divisor,
   output logic [DIV_W-1:0]   quot,
   output logic [DIV_W-1:0]   rem
);
   logic [DIV_W-1:0] part_q, quo_q, dsr_q;
   logic [DIV_W:0]   trial, diff;
   logic             take;

   assign trial = {part_q, quo_q[DIV_W-1]};
   assign diff  = trial - {1'b0, dsr_q};
   assign take  = trial >= {1'b0, dsr_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         part_q <= '0;
         quo_q  <= '0;
         dsr_q  <= '0;
      end else if (load) begin
         part_q <= dividend[2*DIV_W-1:DIV_W];
         quo_q  <= dividend[DIV_W-1:0];
         dsr_q  <= divisor;
      end else if (step) begin
         part_q <= take ? diff[DIV_W-1:0] : trial[DIV_W-1:0];
         quo_q  <= {quo_q[DIV_W-2:0], take};
      end
   end

   assign quot = quo_q;
   assign rem  = part_q;
endmodule

// File: rtl/divu_flags.sv
module divu_flags
   import divu_pkg::*;
#(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DIV_W-1:0] dividend_hi,
   input  logic [DIV_W-1:0] divisor,
   input  flags_t           flags_in,
   output flags_t           flags_nxt,
   output logic             hint_nxt
);
   flags_t flags_comb;
   logic   dz;

   assign dz = (divisor == '0);

   for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
      if (i == FLG_N) begin : g_n
         assign flags_comb[i] = divisor[DIV_W-1];
      end else if (i == FLG_Z) begin : g_z
         assign flags_comb[i] = dz;
      end else begin : g_keep
         assign flags_comb[i] = flags_in[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_nxt <= '0;
         hint_nxt  <= 1'b0;
      end else if (load) begin
         flags_nxt <= flags_comb;
         hint_nxt  <= dz || (dividend_hi >= divisor);
      end
   end
endmodule

// File: rtl/divu_unit.sv
module divu_unit
   import divu_pkg::*;
#(
   parameter int DIV_W   = 16,
   parameter int LATENCY = 22
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [2*DIV_W-1:0] dividend,
   input  logic [DIV_W-1:0]   divisor,
   input  logic [FLAG_W-1:0]  flags_in,
   output logic [2*DIV_W-1:0] result,
   output logic [FLAG_W-1:0]  flags_out,
   output logic               overflow_hint,
   output logic               done,
   output logic               busy
);
   localparam int ITERS = DIV_W;

   if (DIV_W < 2) begin : g_bad_width
      $error("divu_unit: DIV_W must be at least 2");
   end
   if (LATENCY < ITERS + 1) begin : g_bad_latency
      $error("divu_unit: LATENCY too short for the iteration count");
   end

   logic             accept, step, finish;
   logic [DIV_W-1:0] quot, rem;
   flags_t           flags_nxt;
   logic             hint_nxt;

   divu_ctrl #(.LATENCY(LATENCY), .ITERS(ITERS)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .accept(accept), .step(step), .finish(finish),
      .busy(busy), .done(done)
   );

   divu_core #(.DIV_W(DIV_W)) u_core (
      .clk(clk), .rst_n(rst_n), .load(accept), .step(step),
      .dividend(dividend), .divisor(divisor),
      .quot(quot), .rem(rem)
   );

   divu_flags #(.DIV_W(DIV_W)) u_flags (
      .clk(clk), .rst_n(rst_n), .load(accept),
      .dividend_hi(dividend[2*DIV_W-1:DIV_W]), .divisor(divisor),
      .flags_in(flags_in), .flags_nxt(flags_nxt), .hint_nxt(hint_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result        <= '0;
         flags_out     <= '0;
         overflow_hint <= 1'b0;
      end else if (finish) begin
         result        <= {rem, quot};
         flags_out     <= flags_nxt;
         overflow_hint <= hint_nxt;
      end
   end
endmodule

// File: rtl/divu_chk.sv
module divu_chk
   import divu_pkg::*;
#(
   parameter int DIV_W   = 16,
   parameter int LATENCY = 22
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic [2*DIV_W-1:0] dividend,
   input logic [DIV_W-1:0]   divisor,
   input logic [FLAG_W-1:0]  flags_in,
   input logic [2*DIV_W-1:0] result,
   input logic [FLAG_W-1:0]  flags_out,
   input logic               overflow_hint,
   input logic               done,
   input logic               busy
);
   localparam int W2 = 2 * DIV_W;

   logic             ck_active;
   int unsigned      ck_cnt;
   logic [W2-1:0]    cap_dvd;
   logic [DIV_W-1:0] cap_dsr;
   flags_t           cap_flg;
   logic [W2-1:0]    recon;

   assign recon = W2'(result[DIV_W-1:0]) * W2'(cap_dsr) + W2'(result[W2-1:DIV_W]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_active <= 1'b0;
         ck_cnt    <= 0;
         cap_dvd   <= '0;
         cap_dsr   <= '0;
         cap_flg   <= '0;
      end else if (start && !busy) begin
         ck_active <= 1'b1;
         ck_cnt    <= 0;
         cap_dvd   <= dividend;
         cap_dsr   <= divisor;
         cap_flg   <= flags_in;
      end else if (done) begin
         ck_active <= 1'b0;
      end else if (ck_active) begin
         ck_cnt <= ck_cnt + 1;
      end
   end

   AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ck_active && ck_cnt == LATENCY)); // R2
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R2
   AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R3
   AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (ck_active && !done && ck_cnt > 0) |-> busy); // R3
   AST_N_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> flags_out[FLG_N] == cap_dsr[DIV_W-1]); // R4
   AST_Z_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> flags_out[FLG_Z] == (cap_dsr == '0)); // R5
   AST_KEEP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (flags_out[FLG_H] == cap_flg[FLG_H] && flags_out[FLG_V] == cap_flg[FLG_V]
                && flags_out[FLG_C] == cap_flg[FLG_C])); // R6
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> overflow_hint == ((cap_dsr == '0) || (cap_dvd[W2-1:DIV_W] >= cap_dsr))); // R7
   AST_QUOTIENT: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !overflow_hint) |-> (recon == cap_dvd && result[W2-1:DIV_W] < cap_dsr)); // R1
   AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(result) && $stable(flags_out) && $stable(overflow_hint))); // R8
endmodule

bind divu_unit divu_chk #(.DIV_W(DIV_W), .LATENCY(LATENCY)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
   .divisor(divisor), .flags_in(flags_in), .result(result),
   .flags_out(flags_out), .overflow_hint(overflow_hint),
   .done(done), .busy(busy)
);

// File: tb/divu_unit_tb.sv
`timescale 1ns/1ps
module divu_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] dividend = '0;
   logic [15:0] divisor = '0;
   logic [4:0]  flags_in = '0;
   logic [31:0] result;
   logic [4:0]  flags_out;
   logic        overflow_hint, done, busy;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   divu_unit u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
      .divisor(divisor), .flags_in(flags_in), .result(result),
      .flags_out(flags_out), .overflow_hint(overflow_hint),
      .done(done), .busy(busy)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Runs one divide; optionally injects a start with other operands mid-flight.
   task automatic run_op(input logic [31:0] dvd, input logic [15:0] dsr,
                         input logic [4:0] fl, input bit inject, input bit hold);
      logic [4:0] exp_fl;
      logic       exp_hint;
      bit         tim_ok = 1;
      logic [31:0] r_keep;
      dividend = dvd; divisor = dsr; flags_in = fl; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      dividend = ~dvd; divisor = ~dsr; flags_in = ~fl;
      for (int k = 1; k <= 22; k++) begin
         @(negedge clk);
         if (inject && k == 5) begin
            start = 1'b1; dividend = 32'h0000_0001; divisor = 16'h0001; flags_in = 5'h1F;
         end else begin
            start = 1'b0;
         end
         if (k < 22 && (done !== 1'b0 || busy !== 1'b1)) tim_ok = 0;
      end
      start = 1'b0;
      check("R2 done timing", {31'b0, tim_ok}, 32'd1);
      check("R3 idle at done", {30'b0, busy, done}, 32'd1);
      exp_fl   = {fl[4], dsr[15], (dsr == 16'h0), fl[1], fl[0]};
      exp_hint = (dsr == 16'h0) || (dvd[31:16] >= dsr);
      check("R4 N flag", {31'b0, flags_out[3]}, {31'b0, exp_fl[3]});
      check("R5 Z flag", {31'b0, flags_out[2]}, {31'b0, exp_fl[2]});
      check("R6 kept flags", {29'b0, flags_out[4], flags_out[1:0]},
            {29'b0, exp_fl[4], exp_fl[1:0]});
      check("R7 overflow hint", {31'b0, overflow_hint}, {31'b0, exp_hint});
      if (!exp_hint)
         check("R1 quotient/remainder", result, {dvd[15:0] == 16'h0 && 1'b0 ? 16'h0 :
               16'(dvd % {16'h0, dsr}), 16'(dvd / {16'h0, dsr})});
      if (hold) begin
         r_keep = result;
         @(negedge clk);
         check("R2 done one cycle", {31'b0, done}, 32'd0);
         repeat (3) @(negedge clk);
         check("R8 result held", result, r_keep);
         check("R8 flags held", {27'b0, flags_out}, {27'b0, exp_fl});
      end
   endtask

   task automatic t_reset;
      check("R9 reset outputs", {result[31:0]}, 32'h0);
      check("R9 reset ctrl", {24'b0, flags_out, overflow_hint, done, busy}, 32'h0);
   endtask

   task automatic t_basic;
      run_op(32'd1000, 16'd7, 5'b10011, 0, 1);
      run_op(32'h0001_2345, 16'h00F3, 5'b00000, 0, 1);
      run_op(32'h1234_5678, 16'h8001, 5'b10010, 0, 1);   // N from divisor msb
   endtask

   task automatic t_limits;
      run_op(32'hFFFE_FFFF, 16'hFFFF, 5'b00001, 0, 1);   // full quotient, rem = d-1
      run_op(32'h0000_0000, 16'h0005, 5'b11111, 0, 1);
      run_op(32'h7FFF_FFFF, 16'h8000, 5'b00010, 0, 1);
   endtask

   task automatic t_overflow;
      run_op(32'h0000_0042, 16'h0000, 5'b00010, 0, 1);   // zero divisor
      run_op(32'h0005_0000, 16'h0005, 5'b10001, 0, 1);   // hi == divisor
      run_op(32'hFFFF_0000, 16'hFFFF, 5'b01100, 0, 1);
   endtask

   task automatic t_ignore_start;
      run_op(32'h00AB_CDEF, 16'h0123, 5'b00011, 1, 1);   // R3 injected start ignored
   endtask

   task automatic t_back_to_back;
      run_op(32'd99, 16'd10, 5'b00000, 0, 0);
      run_op(32'd123456, 16'd321, 5'b10000, 0, 1);       // R2 start in done cycle
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_basic();
      t_limits();
      t_overflow();
      t_ignore_start();
      t_back_to_back();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule